// File: doc/BRIEF.md
# I2C Host Interrupt Flag Controller

This block keeps the interrupt flag register of an I2C host controller. It also decides when the host must stretch the SCL clock by holding the line low. The host byte engine sends it single-cycle event pulses: byte received, byte transmitted, arbitration lost, bus error, the various timeout and length errors, a NACK lost in arbitration, and a Start issued while the bus state was unknown. The RX and TX FIFOs report their occupancy levels and programmable thresholds. The block turns all of these into five flag bits, a masked interrupt request and an SCL hold request.

Software reaches the block through a small register bus with write and read strobes.

- A write of ones to the flag register clears the chosen flags.
- A separate enable register masks the interrupt request.
- Some other register accesses act only as side effects: an address write, a data write, a data read in smart mode, or a non-zero command. Each of these ends the clock stretch and clears the two bus-ownership flags.

The address and data registers themselves, the FIFOs and the bit-level bus signalling are outside this block.

Top module: `i2c_host_irq_flags`

## Requirements
- R1: While reset is asserted, and at the first edge after it, the flag register (offset 0x0) reads 0x00. Its layout is: bit 7 error, bit 4 RX threshold, bit 3 TX threshold, bit 1 client-on-bus, bit 0 host-on-bus. Bits 6, 5 and 2 always read 0. An offset with no register reads 0x00.
- R2: A write to offset 0x0 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R3: The error flag (bit 7) sets in the cycle after any of six inputs pulses: length error, client extended timeout, host extended timeout, SCL low timeout, arbitration lost, or bus error.
- R4: The RX flag (bit 4) sets when the RX level rises to at or above its threshold. It does not set again while the level stays above the threshold. Hardware clears it when the RX level is 0.
- R5: The TX flag (bit 3) sets when the free TX count (depth minus level) rises to at or above its threshold. Hardware clears it when the TX level equals the depth. An empty TX FIFO after reset therefore sets it.
- R6: The client-on-bus flag (bit 1) sets on a received byte only when there is no arbitration loss and no bus error in that cycle. When it sets, the SCL hold request asserts.
- R7: The host-on-bus flag (bit 0) sets in three cases:
  - a byte is transmitted, whether or not there is a bus error or arbitration loss;
  - arbitration is lost during a NACK;
  - a Start is issued on an unknown bus.
- R8: For the host-on-bus flag, the SCL hold asserts only when arbitration was not lost: a clean transmitted byte or an unknown-bus Start. A byte transmitted with arbitration lost does not hold SCL, and neither does a NACK lost in arbitration.
- R9: Four accesses release the SCL hold and clear bits 1 and 0:
  - a write to offset 0x4 (address);
  - a write to offset 0x5 (data);
  - a read of offset 0x5 while smart mode is on;
  - a write to offset 0x3 (command) with a non-zero value in data bits [1:0].

  A write-1-clear of bits 1 and 0 does not release the hold.
- R10: If a hardware set and a clear (software or hardware) hit the same flag in the same cycle, the set wins. This also applies to the hold: a new hold event in the same cycle as a release leaves the hold asserted.
- R11: The interrupt-enable register sits at offset 0x1, with the same bit layout as the flag register. It reads back what was written. The interrupt request is high exactly when some flag and its enable bit are both 1.
- R12: A command write whose bits [1:0] equal 0 releases nothing. A data read while smart mode is off releases nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the offset on reg_addr_i |
| smart_en_i | input | 1 | Smart mode: a data read acts as a release |
| rx_byte_i | input | 1 | Byte received in host-read mode |
| tx_byte_i | input | 1 | Byte transmitted in host-write mode |
| arb_lost_i | input | 1 | Arbitration lost |
| bus_err_i | input | 1 | Bus error |
| len_err_i | input | 1 | Length error |
| client_tout_i | input | 1 | Client extended timeout |
| host_tout_i | input | 1 | Host extended timeout |
| low_tout_i | input | 1 | SCL low timeout |
| nack_arb_lost_i | input | 1 | Arbitration lost while sending a NACK |
| start_unknown_i | input | 1 | Start issued while the bus state was unknown |
| rx_level_i | input | 4 | RX FIFO occupancy |
| rx_thresh_i | input | 4 | RX threshold (occupied entries) |
| tx_level_i | input | 4 | TX FIFO occupancy |
| tx_thresh_i | input | 4 | TX threshold (free entries) |
| irq_o | output | 1 | Masked interrupt request |
| scl_hold_o | output | 1 | Request to hold SCL low |

## Verification
The assertions take some things for granted about the inputs:
- FIFO levels never exceed the depth.
- Thresholds lie between 1 and the depth.
- Each event arrives as a one-cycle pulse.
- A NACK lost in arbitration is never reported in the same cycle as a clean transmitted byte.

The directed stimulus drives every event for exactly one cycle and keeps the levels and thresholds within range. It sends a hardware set together with a clear or a release only in the test written to check which one wins.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 8;
  localparam int CMD_W  = 2;

  localparam logic [ADDR_W-1:0] OFS_FLAGS = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_ADDR  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 4'h5;

  localparam int BIT_ERR  = 7;
  localparam int BIT_RXT  = 4;
  localparam int BIT_TXT  = 3;
  localparam int BIT_COB  = 1;
  localparam int BIT_HOB  = 0;
  localparam int NFLAGS   = 5;

  // flag slot order inside the internal flag vector
  localparam int SLOT_HOB = 0;
  localparam int SLOT_COB = 1;
  localparam int SLOT_TXT = 2;
  localparam int SLOT_RXT = 3;
  localparam int SLOT_ERR = 4;

  function automatic logic [REG_W-1:0] pack_flags(input logic [NFLAGS-1:0] f);
    logic [REG_W-1:0] r;
    r = '0;
    r[BIT_HOB] = f[SLOT_HOB];
    r[BIT_COB] = f[SLOT_COB];
    r[BIT_TXT] = f[SLOT_TXT];
    r[BIT_RXT] = f[SLOT_RXT];
    r[BIT_ERR] = f[SLOT_ERR];
    return r;
  endfunction

  function automatic logic [NFLAGS-1:0] unpack_flags(input logic [REG_W-1:0] r);
    logic [NFLAGS-1:0] f;
    f[SLOT_HOB] = r[BIT_HOB];
    f[SLOT_COB] = r[BIT_COB];
    f[SLOT_TXT] = r[BIT_TXT];
    f[SLOT_RXT] = r[BIT_RXT];
    f[SLOT_ERR] = r[BIT_ERR];
    return f;
  endfunction
endpackage

// File: rtl/i2c_irq_flag_bit.sv
module i2c_irq_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= set_i | (q_q & ~clr_i);
  end

  assign q_o = q_q;

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/i2c_irq_thresh.sv
module i2c_irq_thresh #(
  parameter int DEPTH      = 8,
  parameter int LVL_W      = $clog2(DEPTH + 1),
  parameter bit COUNT_FREE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic             set_o,
  output logic             clr_o
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  logic [LVL_W-1:0] count;
  logic             hit, hit_q;

  generate
    if (COUNT_FREE) begin : g_free
      assign count = DEPTH_L - level_i;
      assign clr_o = (level_i == DEPTH_L);
    end else begin : g_used
      assign count = level_i;
      assign clr_o = (level_i == '0);
    end
  endgenerate

  assign hit = (count >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit;
  end

  assign set_o = hit & ~hit_q;

  assert_level_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= DEPTH_L);
  assert_thresh_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thresh_i != '0) && (thresh_i <= DEPTH_L));
  assert_no_reset_after_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> !set_o);
endmodule

// File: rtl/i2c_irq_release.sv
module i2c_irq_release
  import i2c_irq_pkg::*;
(
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              smart_en_i,
  output logic              release_o
);
  logic addr_wr, data_wr, data_rd, cmd_wr;

  always_comb begin
    addr_wr = reg_wr_i && (reg_addr_i == OFS_ADDR);
    data_wr = reg_wr_i && (reg_addr_i == OFS_DATA);
    data_rd = reg_rd_i && smart_en_i && (reg_addr_i == OFS_DATA);
    cmd_wr  = reg_wr_i && (reg_addr_i == OFS_CMD) && (cmd_i != '0);
  end

  assign release_o = addr_wr | data_wr | data_rd | cmd_wr;

  always_comb begin
    assert_cmd_zero_R12: assert (!(reg_wr_i && reg_addr_i == OFS_CMD && cmd_i == '0) || !release_o);
    assert_rd_no_smart_R12: assert (!(reg_rd_i && !reg_wr_i && !smart_en_i) || !release_o);
  end
endmodule

// File: rtl/i2c_host_irq_flags.sv
module i2c_host_irq_flags
  import i2c_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              smart_en_i,
  input  logic              rx_byte_i,
  input  logic              tx_byte_i,
  input  logic              arb_lost_i,
  input  logic              bus_err_i,
  input  logic              len_err_i,
  input  logic              client_tout_i,
  input  logic              host_tout_i,
  input  logic              low_tout_i,
  input  logic              nack_arb_lost_i,
  input  logic              start_unknown_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  rx_thresh_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  tx_thresh_i,
  output logic              irq_o,
  output logic              scl_hold_o
);
  logic [NFLAGS-1:0] set_v, clr_v, w1c_v, hw_clr_v, flags;
  logic [REG_W-1:0]  flag_reg, ien_q;
  logic              rx_set, rx_clr, tx_set, tx_clr;
  logic              rel, err_any, cob_set, hob_set, hold_set, hold_q;
  logic              flags_wr;

  i2c_irq_thresh #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .COUNT_FREE(1'b0)) u_rx_thr (
    .clk_i, .rst_ni, .level_i(rx_level_i), .thresh_i(rx_thresh_i),
    .set_o(rx_set), .clr_o(rx_clr));

  i2c_irq_thresh #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .COUNT_FREE(1'b1)) u_tx_thr (
    .clk_i, .rst_ni, .level_i(tx_level_i), .thresh_i(tx_thresh_i),
    .set_o(tx_set), .clr_o(tx_clr));

  i2c_irq_release u_rel (
    .reg_wr_i, .reg_rd_i, .reg_addr_i, .cmd_i(reg_wdata_i[CMD_W-1:0]),
    .smart_en_i, .release_o(rel));

  always_comb begin
    err_any  = len_err_i | client_tout_i | host_tout_i | low_tout_i | arb_lost_i | bus_err_i;
    cob_set  = rx_byte_i & ~arb_lost_i & ~bus_err_i;
    hob_set  = tx_byte_i | nack_arb_lost_i | start_unknown_i;
    // stretch only when arbitration still held
    hold_set = cob_set | (tx_byte_i & ~arb_lost_i) | start_unknown_i;
    flags_wr = reg_wr_i && (reg_addr_i == OFS_FLAGS);
  end

  always_comb begin
    set_v           = '0;
    set_v[SLOT_ERR] = err_any;
    set_v[SLOT_RXT] = rx_set;
    set_v[SLOT_TXT] = tx_set;
    set_v[SLOT_COB] = cob_set;
    set_v[SLOT_HOB] = hob_set;
    hw_clr_v           = '0;
    hw_clr_v[SLOT_RXT] = rx_clr;
    hw_clr_v[SLOT_TXT] = tx_clr;
    hw_clr_v[SLOT_COB] = rel;
    hw_clr_v[SLOT_HOB] = rel;
    w1c_v = flags_wr ? unpack_flags(reg_wdata_i) : '0;
    clr_v = w1c_v | hw_clr_v;
  end

  generate
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      i2c_irq_flag_bit u_bit (
        .clk_i, .rst_ni, .set_i(set_v[i]), .clr_i(clr_v[i]), .q_o(flags[i]));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      ien_q  <= '0;
    end else begin
      hold_q <= hold_set | (hold_q & ~rel);
      if (reg_wr_i && reg_addr_i == OFS_IEN) ien_q <= pack_flags(unpack_flags(reg_wdata_i));
    end
  end

  assign flag_reg   = pack_flags(flags);
  assign scl_hold_o = hold_q;
  assign irq_o      = |(flag_reg & ien_q);

  always_comb begin
    unique case (reg_addr_i)
      OFS_FLAGS: reg_rdata_o = flag_reg;
      OFS_IEN:   reg_rdata_o = ien_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_err_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_any |=> reg_rdata_o[BIT_ERR] || (reg_addr_i != OFS_FLAGS));
  assert_cob_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_byte_i && !arb_lost_i && !bus_err_i) |=> scl_hold_o);
  assert_cob_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_byte_i && (arb_lost_i || bus_err_i) && !flags[SLOT_COB]) |=> !flags[SLOT_COB]);
  assert_hob_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_byte_i || nack_arb_lost_i || start_unknown_i) |=> flags[SLOT_HOB]);
  assert_no_hold_arb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_hold_o && arb_lost_i && !rx_byte_i && !start_unknown_i) |=> !scl_hold_o);
  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel && !rx_byte_i && !tx_byte_i && !start_unknown_i) |=> !scl_hold_o);
  assert_hold_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && !rel) |=> scl_hold_o);
  assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFS_FLAGS) |-> (reg_rdata_o[6:5] == 2'b00 && reg_rdata_o[2] == 1'b0));
  assert_irq_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/i2c_host_irq_flags_test.sv
module i2c_host_irq_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, smart = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00, rdata;
  logic [9:0] ev = '0;
  logic [3:0] rx_lvl = 4'd0, rx_thr = 4'd4, tx_lvl = 4'd0, tx_thr = 4'd4;
  logic       irq, hold;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  i2c_host_irq_flags uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .smart_en_i(smart),
    .rx_byte_i(ev[0]), .tx_byte_i(ev[1]), .arb_lost_i(ev[2]), .bus_err_i(ev[3]),
    .len_err_i(ev[4]), .client_tout_i(ev[5]), .host_tout_i(ev[6]), .low_tout_i(ev[7]),
    .nack_arb_lost_i(ev[8]), .start_unknown_i(ev[9]),
    .rx_level_i(rx_lvl), .rx_thresh_i(rx_thr), .tx_level_i(tx_lvl), .tx_thresh_i(tx_thr),
    .irq_o(irq), .scl_hold_o(hold));

  localparam logic [9:0] E_RX = 10'h001, E_TX = 10'h002, E_ARB = 10'h004, E_BUS = 10'h008,
                         E_NACK = 10'h100, E_START = 10'h200;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one-cycle stimulus: events plus optional register access, checked after the edge
  task automatic step(input logic [9:0] e, input logic w, input logic r,
                      input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    ev = e; wr = w; rd = r; addr = a; wdata = d;
    @(negedge clk);
    ev = '0; wr = 1'b0; rd = 1'b0; addr = 4'h0; wdata = 8'h00;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    step('0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = 4'h0;
  endtask

  task automatic chk_flags(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rreg(4'h0, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    #1 v = rdata;
    chk("R1 flags in reset", v, 8'h00);
    chk("R1 hold in reset", {7'd0, hold}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_flags("R1/R5 flags after reset (TX empty sets bit3)", 8'h08);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    rreg(4'h7, v);
    chk("R1 unmapped offset", v, 8'h00);
  endtask

  task automatic t_w1c;
    wreg(4'h0, 8'h00);
    chk_flags("R2 write 0 keeps flag", 8'h08);
    wreg(4'h0, 8'h08);
    chk_flags("R2 write 1 clears flag", 8'h00);
  endtask

  task automatic t_errors;
    for (int i = 2; i < 8; i++) begin
      step(10'(1) << i, 1'b0, 1'b0, 4'h0, 8'h00);
      chk_flags($sformatf("R3 error source %0d", i), 8'h80);
      wreg(4'h0, 8'h80);
    end
    chk_flags("R3 error cleared", 8'h00);
  endtask

  task automatic t_rx;
    @(negedge clk); rx_lvl = 4'd3;
    @(negedge clk);
    chk_flags("R4 below threshold", 8'h00);
    rx_lvl = 4'd4;
    @(negedge clk);
    chk_flags("R4 threshold reached", 8'h10);
    wreg(4'h0, 8'h10);
    rx_lvl = 4'd5;
    @(negedge clk); @(negedge clk);
    chk_flags("R4 no re-set above threshold", 8'h00);
    rx_lvl = 4'd2; @(negedge clk);
    rx_lvl = 4'd4; @(negedge clk);
    chk_flags("R4 set again", 8'h10);
    rx_lvl = 4'd0; @(negedge clk);
    chk_flags("R4 hw clear on empty", 8'h00);
  endtask

  task automatic t_tx;
    @(negedge clk); tx_lvl = 4'd8;
    @(negedge clk);
    tx_lvl = 4'd4;
    @(negedge clk);
    chk_flags("R5 free reaches threshold", 8'h08);
    tx_lvl = 4'd8;
    @(negedge clk);
    chk_flags("R5 hw clear on full", 8'h00);
  endtask

  task automatic t_cob;
    step(E_RX | E_ARB, 1'b0, 1'b0, 4'h0, 8'h00);
    chk_flags("R6 no COB on arb lost", 8'h80);
    chk("R6 no hold on arb lost", {7'd0, hold}, 8'h00);
    wreg(4'h0, 8'h80);
    step(E_RX | E_BUS, 1'b0, 1'b0, 4'h0, 8'h00);
    chk_flags("R6 no COB on bus error", 8'h80);
    wreg(4'h0, 8'h80);
    step(E_RX, 1'b0, 1'b0, 4'h0, 8'h00);
    chk_flags("R6 COB set", 8'h02);
    chk("R6 hold set", {7'd0, hold}, 8'h01);
    wreg(4'h0, 8'h02);
    chk_flags("R9 w1c clears COB", 8'h00);
    chk("R9 w1c keeps hold", {7'd0, hold}, 8'h01);
    wreg(4'h5, 8'h5a);
    chk("R9 data write releases", {7'd0, hold}, 8'h00);
  endtask

  task automatic t_hob;
    step(10'h002 | E_ARB, 1'b0, 1'b0, 4'h0, 8'h00);
    chk_flags("R7 HOB despite arb lost", 8'h81);
    chk("R8 no hold when arb lost", {7'd0, hold}, 8'h00);
    wreg(4'h0, 8'h81);
    step(E_NACK, 1'b0, 1'b0, 4'h0, 8'h00);
    chk_flags("R7 HOB on NACK arb lost", 8'h01);
    chk("R8 no hold on NACK arb lost", {7'd0, hold}, 8'h00);
    wreg(4'h0, 8'h01);
    step(E_START, 1'b0, 1'b0, 4'h0, 8'h00);
    chk_flags("R7 HOB on unknown-bus start", 8'h01);
    chk("R8 hold on unknown-bus start", {7'd0, hold}, 8'h01);
    wreg(4'h3, 8'h00);
    chk("R12 cmd 0 keeps hold", {7'd0, hold}, 8'h01);
    chk_flags("R12 cmd 0 keeps HOB", 8'h01);
    wreg(4'h3, 8'h01);
    chk("R9 cmd release", {7'd0, hold}, 8'h00);
    chk_flags("R9 cmd clears HOB", 8'h00);
    step(E_TX, 1'b0, 1'b0, 4'h0, 8'h00);
    chk("R8 hold on clean tx", {7'd0, hold}, 8'h01);
    wreg(4'h4, 8'h42);
    chk("R9 addr write releases", {7'd0, hold}, 8'h00);
    step(E_RX, 1'b0, 1'b0, 4'h0, 8'h00);
    smart = 1'b0;
    step('0, 1'b0, 1'b1, 4'h5, 8'h00);
    chk("R12 data read no smart keeps hold", {7'd0, hold}, 8'h01);
    smart = 1'b1;
    step('0, 1'b0, 1'b1, 4'h5, 8'h00);
    chk("R9 smart data read releases", {7'd0, hold}, 8'h00);
    smart = 1'b0;
    chk_flags("R9 flags after smart read", 8'h00);
  endtask

  task automatic t_set_wins;
    step(E_RX, 1'b1, 1'b0, 4'h0, 8'h02);
    chk_flags("R10 set beats w1c", 8'h02);
    step(E_RX, 1'b1, 1'b0, 4'h5, 8'h00);
    chk("R10 set beats release (hold)", {7'd0, hold}, 8'h01);
    chk_flags("R10 set beats release (flag)", 8'h02);
    wreg(4'h5, 8'h00);
    chk_flags("R10 cleanup", 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wreg(4'h1, 8'h80);
    rreg(4'h1, v);
    chk("R11 enable readback", v, 8'h80);
    chk("R11 irq idle", {7'd0, irq}, 8'h00);
    step(10'h010, 1'b0, 1'b0, 4'h0, 8'h00);
    chk("R11 irq on enabled flag", {7'd0, irq}, 8'h01);
    wreg(4'h1, 8'h01);
    chk("R11 irq masked", {7'd0, irq}, 8'h00);
    chk_flags("R11 flag stays when masked", 8'h80);
    wreg(4'h0, 8'h80);
  endtask

  initial begin
    fork
      begin
        t_reset; t_w1c; t_errors; t_rx; t_tx; t_cob; t_hob; t_set_wins; t_irq;
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule